// File: doc/BRIEF.md
# Serial Word Load and Frame Sync Generator

This block produces the framing strobes for a serial port running in active mode. A small programmable divider turns the system clock into a bit-rate tick. From that tick, a word timer creates the input-load and output-load strobes. Each strobe is active low and falls at the start of every 16-bit word.

A frame timer counts words. When the sync pin is configured as an output, the block drives it low together with the load strobe of the first word of each frame. A frame is either 8 or 16 words long, chosen by a rate select. When the sync pin is configured as an input, the block watches it for a falling edge. Such an edge marks the first word of an incoming time-division-multiplexed stream. On that edge the block restarts its word and frame counters, so that both load strobes line up with the external frame.

Every output comes from a register. Reset is synchronous and active high.

Top module: `sio_frame_gen`

## Requirements
- R1: The bit period is `bit_div`+1 system clocks. With `bit_div`=2, the load strobes are low on clock edges 48, 49 and 50 after reset release, and then on every 48th edge after those.
- R2: `ild_n` and `old_n` are identical. Each goes low for exactly one bit period, once every 16 bit periods.
- R3: With `sync_rate`=0 a frame is 8 words long; with `sync_rate`=1 it is 16 words long. `sync_o` is low only during the bit in which the load strobe of a frame's first word is low.
- R4: `sync_oe` equals `sync_dir` as sampled at the previous clock edge. `sync_o` stays high outside frame-start bits.
- R5: This requirement applies when `sync_dir`=0. Suppose `sync_in` is first sampled low at clock edge k after being high. Then the load strobes and `sync_o` stay high through edge k+2, and all three go low at the first bit tick after edge k+2 (edge k+3 when `bit_div`=0). After that, the strobes repeat every 16 bits from that point, and that word starts a new frame.
- R6: When `sync_dir`=1, a falling edge on `sync_in` has no effect on the strobe schedule.
- R7: While `rst` is high, both strobes and `sync_o` are high and `sync_oe` is low. After reset release, the first strobe falls on the 16th bit tick. That first word is also a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_div | input | DIV_W | Bit period minus one, counted in system clocks |
| sync_dir | input | 1 | 1: drive the sync pin; 0: use the sync pin as an input |
| sync_rate | input | 1 | Frame length select: 0 = 8 words, 1 = 16 words |
| sync_in | input | 1 | External frame sync; a falling edge restarts the framing |
| ild_n | output | 1 | Input word load strobe, active low |
| old_n | output | 1 | Output word load strobe, active low |
| sync_o | output | 1 | Generated frame sync, active low |
| sync_oe | output | 1 | Output enable for the sync pin |

## Verification
A wrong bit counter shows up at the load strobes within one word of 16 bits: the strobe falls early or late, or its spacing stops being 16 bits. A wrong frame counter shows up only at `sync_o`, and can take up to one full frame of 16 words to show. For this reason the bench watches at least two frame starts at each rate. A fault in the edge detector or the resynchronisation logic shows up three clocks after the external sync falls, as a strobe that is missing or placed wrongly. In output mode the same fault shows up as a strobe that shifts when it should not.

// File: rtl/sio_frame_pkg.sv
package sio_frame_pkg;
  localparam int unsigned DEF_DIV_W      = 8;
  localparam int unsigned DEF_WORD_BITS  = 16;
  localparam int unsigned DEF_FRAME_SHORT = 8;
  localparam int unsigned DEF_FRAME_LONG  = 16;
  localparam int unsigned DEF_NUM_LOADS  = 2;
  localparam int unsigned SYNC_STAGES    = 3;
endpackage

// File: rtl/sio_bit_divider.sv
module sio_bit_divider
  import sio_frame_pkg::*;
#(
  parameter int unsigned DIV_W = DEF_DIV_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] bit_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= bit_div);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // While the divisor is held, the phase counter never passes it
  assert_div_bound_R1: assert property (@(posedge clk) disable iff (rst)
    $stable(bit_div) |-> (cnt <= bit_div));
endmodule

// File: rtl/sio_word_timer.sv
module sio_word_timer
  import sio_frame_pkg::*;
#(
  parameter int unsigned WORD_BITS = DEF_WORD_BITS
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic resync,
  output logic word_start
);
  localparam int unsigned CW = $clog2(WORD_BITS);
  localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

  logic [CW-1:0] bit_cnt;

  assign word_start = tick && !resync && (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)         bit_cnt <= '0;
    else if (resync) bit_cnt <= LAST;
    else if (tick)   bit_cnt <= word_start ? '0 : bit_cnt + 1'b1;
  end

  // A resync leaves the counter one bit short of a word boundary
  assert_resync_arm_R5: assert property (@(posedge clk) disable iff (rst)
    resync |=> (bit_cnt == LAST));

  // A word boundary always restarts the bit count
  assert_word_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    word_start |=> (bit_cnt == '0));
endmodule

// File: rtl/sio_frame_timer.sv
module sio_frame_timer
  import sio_frame_pkg::*;
#(
  parameter int unsigned FRAME_SHORT = DEF_FRAME_SHORT,
  parameter int unsigned FRAME_LONG  = DEF_FRAME_LONG
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic word_start,
  input  logic resync,
  input  logic rate_long,
  output logic sync_n
);
  localparam int unsigned FW = $clog2(FRAME_LONG);
  localparam logic [FW-1:0] TOP = FW'(FRAME_LONG - 1);

  logic [FW-1:0] frm_cnt;
  logic [FW-1:0] last_idx;
  logic          frame_first;

  assign last_idx    = rate_long ? FW'(FRAME_LONG - 1) : FW'(FRAME_SHORT - 1);
  assign frame_first = (frm_cnt >= last_idx);

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      frm_cnt <= TOP;
      sync_n  <= 1'b1;
    end else if (word_start) begin
      frm_cnt <= frame_first ? '0 : frm_cnt + 1'b1;
      sync_n  <= !frame_first;
    end else if (tick) begin
      sync_n  <= 1'b1;
    end
  end

  // The frame sync falls only at a word boundary
  assert_sync_on_word_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> $past(word_start));

  // A falling frame sync means the frame count has restarted
  assert_frame_restart_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_n) |-> (frm_cnt == '0));
endmodule

// File: rtl/sio_frame_gen.sv
module sio_frame_gen
  import sio_frame_pkg::*;
#(
  parameter int unsigned DIV_W       = DEF_DIV_W,
  parameter int unsigned WORD_BITS   = DEF_WORD_BITS,
  parameter int unsigned FRAME_SHORT = DEF_FRAME_SHORT,
  parameter int unsigned FRAME_LONG  = DEF_FRAME_LONG,
  parameter int unsigned NUM_LOADS   = DEF_NUM_LOADS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] bit_div,
  input  logic             sync_dir,
  input  logic             sync_rate,
  input  logic             sync_in,
  output logic             ild_n,
  output logic             old_n,
  output logic             sync_o,
  output logic             sync_oe
);
  logic                   tick;
  logic                   word_start;
  logic                   resync;
  logic [SYNC_STAGES-1:0] sync_sh;
  logic [NUM_LOADS-1:0]   ld_q;
  logic                   oe_q;

  sio_bit_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .bit_div(bit_div), .tick(tick)
  );

  // Two-flop synchroniser plus one stage for falling-edge detection
  always_ff @(posedge clk) begin
    if (rst) sync_sh <= '1;
    else     sync_sh <= {sync_sh[SYNC_STAGES-2:0], sync_in};
  end

  assign resync = !sync_dir && sync_sh[SYNC_STAGES-1] && !sync_sh[SYNC_STAGES-2];

  sio_word_timer #(.WORD_BITS(WORD_BITS)) u_word (
    .clk(clk), .rst(rst), .tick(tick), .resync(resync), .word_start(word_start)
  );

  sio_frame_timer #(.FRAME_SHORT(FRAME_SHORT), .FRAME_LONG(FRAME_LONG)) u_frame (
    .clk(clk), .rst(rst), .tick(tick), .word_start(word_start),
    .resync(resync), .rate_long(sync_rate), .sync_n(sync_o)
  );

  // One registered strobe per load generator
  for (genvar g = 0; g < NUM_LOADS; g++) begin : g_load
    always_ff @(posedge clk) begin
      if (rst || resync) ld_q[g] <= 1'b1;
      else if (tick)     ld_q[g] <= !word_start;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= sync_dir;
  end

  assign ild_n   = ld_q[0];
  assign old_n   = ld_q[NUM_LOADS-1];
  assign sync_oe = oe_q;

  // The frame sync is low only inside a load strobe
  assert_sync_in_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !sync_o |-> !ld_q[0]);

  // Output enable tracks the direction control one clock later
  assert_oe_track_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sync_oe == $past(sync_dir)));

  // In output mode the external sync never restarts the framing
  assert_ignore_ext_R6: assert property (@(posedge clk) disable iff (rst)
    $past(sync_dir) && $fell(sync_sh[SYNC_STAGES-1]) |-> !$past(resync));
endmodule

// File: tb/sio_frame_gen_test.sv
`timescale 1ns/1ps
module sio_frame_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bit_div = '0;
  logic       sync_dir = 1'b0;
  logic       sync_rate = 1'b0;
  logic       sync_in = 1'b1;
  logic       ild_n, old_n, sync_o, sync_oe;

  int tests = 0;
  int fails = 0;
  int n = 0;

  always #2.5 clk = ~clk;

  sio_frame_gen uut (
    .clk(clk), .rst(rst), .bit_div(bit_div), .sync_dir(sync_dir),
    .sync_rate(sync_rate), .sync_in(sync_in), .ild_n(ild_n), .old_n(old_n),
    .sync_o(sync_o), .sync_oe(sync_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    n++;
  endtask

  task automatic do_reset(input logic [7:0] div, input logic dir, input logic rate);
    @(negedge clk);
    rst = 1'b1; bit_div = div; sync_dir = dir; sync_rate = rate; sync_in = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; sync_dir = 1'b1;
    repeat (3) @(negedge clk);
    check(ild_n == 1'b1, "R7 ild_n in reset", ild_n, 1);
    check(old_n == 1'b1, "R7 old_n in reset", old_n, 1);
    check(sync_o == 1'b1, "R7 sync_o in reset", sync_o, 1);
    check(sync_oe == 1'b0, "R7 sync_oe in reset", sync_oe, 0);
  endtask

  task automatic t_period();
    do_reset(8'd0, 1'b0, 1'b0);
    for (int i = 1; i <= 64; i++) begin
      step();
      check(ild_n == !(n % 16 == 0), "R2 R7 ild_n schedule", ild_n, !(n % 16 == 0));
      check(old_n == ild_n, "R2 old_n equals ild_n", old_n, ild_n);
    end
  endtask

  task automatic t_sync(input logic rate);
    int flen;
    bit exp_low;
    flen = rate ? 16 : 8;
    do_reset(8'd0, 1'b1, rate);
    for (int i = 1; i <= 300; i++) begin
      step();
      exp_low = (n % 16 == 0) && (((n / 16) - 1) % flen == 0);
      check(sync_o == !exp_low, rate ? "R3 sync_o rate 16" : "R3 sync_o rate 8",
            sync_o, !exp_low);
      check(sync_oe == 1'b1, "R4 sync_oe in output mode", sync_oe, 1);
    end
  endtask

  task automatic t_divider();
    bit exp_low;
    do_reset(8'd2, 1'b0, 1'b0);
    for (int i = 1; i <= 110; i++) begin
      step();
      exp_low = (n >= 48) && ((n / 3) % 16 == 0);
      check(ild_n == !exp_low, "R1 divided strobe", ild_n, !exp_low);
    end
  endtask

  task automatic t_resync();
    bit exp_low;
    do_reset(8'd0, 1'b0, 1'b0);
    repeat (5) step();
    sync_in = 1'b0;
    for (int m = 1; m <= 30; m++) begin
      step();
      exp_low = (m == 4) || (m == 20);
      check(ild_n == !exp_low, "R5 ild_n after resync", ild_n, !exp_low);
      check(old_n == !exp_low, "R5 old_n after resync", old_n, !exp_low);
      check(sync_o == !(m == 4), "R5 sync_o after resync", sync_o, !(m == 4));
      check(sync_oe == 1'b0, "R4 sync_oe in input mode", sync_oe, 0);
    end
    sync_in = 1'b1;
  endtask

  task automatic t_ignore();
    do_reset(8'd0, 1'b1, 1'b0);
    repeat (5) step();
    sync_in = 1'b0;
    for (int i = 1; i <= 40; i++) begin
      step();
      check(ild_n == !(n % 16 == 0), "R6 sync_in ignored in output mode",
            ild_n, !(n % 16 == 0));
    end
    sync_in = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_period();
    t_sync(1'b0);
    t_sync(1'b1);
    t_divider();
    t_resync();
    t_ignore();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule